// File: doc/BRIEF.md
# Five-Stage Pipeline Hazard Controller

This block is the control unit for an in-order pipeline with five stages: fetch, decode, execute, memory and writeback. The block keeps an occupancy bit for each stage from decode to writeback. It compares the source register fields of the instruction in decode with the destinations of older instructions. It also watches the branch outcome, which only becomes known in the memory stage. From these it drives the program-counter enable, a hold for the fetch/decode register, a bubble for the decode/execute register and squash strobes for the three younger stage registers.

The block has no forwarding network, so any read-after-write dependence on a producer in execute or memory is resolved by stalling. Writeback needs no stall: the register file writes in the first half of the cycle, so a read of the same register in decode that cycle already sees the new value. A taken branch in the memory stage discards everything fetched after it, and this flush takes priority over any stall raised in the same cycle. The datapath reports the instruction entering decode through `fetch_vld`. The outputs `id_vld`, `ex_vld`, `mem_vld` and `wb_vld` show which stages hold a live instruction. The asynchronous reset is synchronized inside the block and takes effect on release after two clock edges.

Top module: `hz_pipe_ctrl`

## Requirements
- R1: While reset is held, all four stage occupancy bits are 0, `pc_we` is 1, and `ifid_hold`, `idex_bubble` and the three squash strobes are 0.
- R2: With no hazard, `id_vld` takes `fetch_vld` at each clock edge, and each older occupancy bit takes the value of the stage before it, one stage per cycle.
- R3: A decode instruction that is valid and has a used, nonzero source equal to the destination of a valid, write-enabled instruction in execute causes `pc_we`=0, `ifid_hold`=1 and `idex_bubble`=1 in that cycle. At the next edge `id_vld` stays 1, `ex_vld` becomes 0, and memory and writeback advance.
- R4: The same dependence on a valid, write-enabled instruction in the memory stage causes the same stall as R3.
- R5: Once the producer has moved on to writeback, so that neither execute nor memory matches, the stall is released in that same cycle and `pc_we` returns to 1.
- R6: A source address of 0 never causes a stall, even when a valid, write-enabled older destination is also 0.
- R7: No stall arises when the matching source has its use flag at 0, when the producer's write enable is 0, when the producer's stage is not valid, or when decode is not valid.
- R8: When `mem_br_taken`=1 and `mem_vld`=1, `ifid_squash`, `idex_squash` and `exmem_squash` are 1 and `pc_we` is 1. At the next edge `id_vld`, `ex_vld` and `mem_vld` become 0 and `wb_vld` becomes 1.
- R9: When a flush and a data stall occur in the same cycle, the flush wins: `ifid_hold` and `idex_bubble` stay 0 and `pc_we` is 1.
- R10: `mem_br_taken` has no effect while `mem_vld` is 0. No squash strobe rises, and the occupancy bits advance as in R2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| fetch_vld | input | 1 | A valid instruction enters decode at the next edge |
| id_src_addr | input | NUM_SRC*REG_AW | Source register fields of the decode instruction; source k occupies bits k*REG_AW upward |
| id_src_use | input | NUM_SRC | Bit k set when source k is actually read |
| ex_wen | input | 1 | Execute-stage instruction writes a register |
| ex_rd | input | REG_AW | Execute-stage destination register |
| mem_wen | input | 1 | Memory-stage instruction writes a register |
| mem_rd | input | REG_AW | Memory-stage destination register |
| mem_br_taken | input | 1 | Branch in the memory stage is taken |
| pc_we | output | 1 | Program counter update enable |
| ifid_hold | output | 1 | Hold the fetch/decode register |
| idex_bubble | output | 1 | Load a no-op into the decode/execute register |
| ifid_squash | output | 1 | Invalidate the fetch/decode register |
| idex_squash | output | 1 | Invalidate the decode/execute register |
| exmem_squash | output | 1 | Invalidate the execute/memory register |
| id_vld | output | 1 | Decode stage holds a live instruction |
| ex_vld | output | 1 | Execute stage holds a live instruction |
| mem_vld | output | 1 | Memory stage holds a live instruction |
| wb_vld | output | 1 | Writeback stage holds a live instruction |

## Verification
The bench drives a dependence that moves from execute to memory to writeback. A design that also compared against writeback would stall one cycle too long. A design that forgot the memory comparison would release one cycle too early. Register 0, unused sources, disabled writes and empty producer or consumer stages each get their own step, because a match that skips any of these qualifiers would raise a false bubble. A taken branch arriving in the same cycle as a stall shows whether the flush has priority: a wrong design would hold the fetch register while squashing it. A taken flag raised with an empty memory stage shows whether the design squashes on an unqualified flag.

// File: rtl/hz_pkg.sv
package hz_pkg;

  typedef struct packed {
    logic id;
    logic ex;
    logic mem;
    logic wb;
  } stage_occ_t;

  localparam stage_occ_t OCC_EMPTY = '{id: 1'b0, ex: 1'b0, mem: 1'b0, wb: 1'b0};

  typedef enum logic [1:0] {
    ACT_FLOW  = 2'd0,
    ACT_STALL = 2'd1,
    ACT_FLUSH = 2'd2
  } pipe_act_t;

endpackage

// File: rtl/hz_rst_sync.sv
module hz_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_q_n
);
  localparam int unsigned TOP = STAGES - 1;

  logic [TOP:0] chain_q;
  logic [TOP:0] chain_d;

  always_comb begin
    chain_d = {chain_q[TOP-1:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain_q <= '0;
    end else begin
      chain_q <= chain_d;
    end
  end

  assign rst_q_n = chain_q[TOP];
endmodule

// File: rtl/hz_dep_detect.sv
module hz_dep_detect #(
  parameter int unsigned REG_AW  = 5,
  parameter int unsigned NUM_SRC = 2
) (
  input  logic                      id_occ,
  input  logic [NUM_SRC*REG_AW-1:0] src_addr,
  input  logic [NUM_SRC-1:0]        src_use,
  input  logic                      ex_occ,
  input  logic                      ex_wen,
  input  logic [REG_AW-1:0]         ex_rd,
  input  logic                      mem_occ,
  input  logic                      mem_wen,
  input  logic [REG_AW-1:0]         mem_rd,
  output logic                      dep_hit
);
  logic               ex_live;
  logic               mem_live;
  logic [NUM_SRC-1:0] src_hit;

  always_comb begin
    ex_live  = ex_occ && ex_wen && (ex_rd != '0);
    mem_live = mem_occ && mem_wen && (mem_rd != '0);
  end

  for (genvar k = 0; k < NUM_SRC; k++) begin : g_src
    logic [REG_AW-1:0] addr_k;
    logic              ex_match;
    logic              mem_match;
    always_comb begin
      addr_k    = src_addr[k*REG_AW +: REG_AW];
      ex_match  = ex_live && (ex_rd == addr_k);
      mem_match = mem_live && (mem_rd == addr_k);
      src_hit[k] = src_use[k] && (addr_k != '0) && (ex_match || mem_match);
    end
  end

  always_comb begin
    dep_hit = id_occ && (|src_hit);
  end
endmodule

// File: rtl/hz_occ_track.sv
module hz_occ_track
  import hz_pkg::*;
(
  input  logic       clk,
  input  logic       rst_q_n,
  input  logic       fetch_vld,
  input  pipe_act_t  act,
  output stage_occ_t occ
);
  stage_occ_t occ_q;
  stage_occ_t occ_d;

  always_comb begin
    occ_d = occ_q;
    unique case (act)
      ACT_FLUSH: begin
        occ_d.id  = 1'b0;
        occ_d.ex  = 1'b0;
        occ_d.mem = 1'b0;
        occ_d.wb  = occ_q.mem;
      end
      ACT_STALL: begin
        occ_d.id  = occ_q.id;
        occ_d.ex  = 1'b0;
        occ_d.mem = occ_q.ex;
        occ_d.wb  = occ_q.mem;
      end
      default: begin
        occ_d.id  = fetch_vld;
        occ_d.ex  = occ_q.id;
        occ_d.mem = occ_q.ex;
        occ_d.wb  = occ_q.mem;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_q_n) begin
    if (!rst_q_n) begin
      occ_q <= OCC_EMPTY;
    end else begin
      occ_q <= occ_d;
    end
  end

  assign occ = occ_q;
endmodule

// File: rtl/hz_pipe_ctrl.sv
module hz_pipe_ctrl
  import hz_pkg::*;
#(
  parameter int unsigned REG_AW   = 5,
  parameter int unsigned NUM_SRC  = 2,
  parameter int unsigned SYNC_LEN = 2
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      fetch_vld,
  input  logic [NUM_SRC*REG_AW-1:0] id_src_addr,
  input  logic [NUM_SRC-1:0]        id_src_use,
  input  logic                      ex_wen,
  input  logic [REG_AW-1:0]         ex_rd,
  input  logic                      mem_wen,
  input  logic [REG_AW-1:0]         mem_rd,
  input  logic                      mem_br_taken,
  output logic                      pc_we,
  output logic                      ifid_hold,
  output logic                      idex_bubble,
  output logic                      ifid_squash,
  output logic                      idex_squash,
  output logic                      exmem_squash,
  output logic                      id_vld,
  output logic                      ex_vld,
  output logic                      mem_vld,
  output logic                      wb_vld
);
  logic       rst_q_n;
  logic       dep_hit;
  logic       flush;
  pipe_act_t  act;
  stage_occ_t occ;

  hz_rst_sync #(.STAGES(SYNC_LEN)) u_rst (
    .clk     (clk),
    .rst_n   (rst_n),
    .rst_q_n (rst_q_n)
  );

  hz_dep_detect #(.REG_AW(REG_AW), .NUM_SRC(NUM_SRC)) u_dep (
    .id_occ   (occ.id),
    .src_addr (id_src_addr),
    .src_use  (id_src_use),
    .ex_occ   (occ.ex),
    .ex_wen   (ex_wen),
    .ex_rd    (ex_rd),
    .mem_occ  (occ.mem),
    .mem_wen  (mem_wen),
    .mem_rd   (mem_rd),
    .dep_hit  (dep_hit)
  );

  // priority: a resolved taken branch beats any data stall
  always_comb begin
    flush = mem_br_taken && occ.mem;
    if (flush) begin
      act = ACT_FLUSH;
    end else if (dep_hit) begin
      act = ACT_STALL;
    end else begin
      act = ACT_FLOW;
    end
  end

  hz_occ_track u_occ (
    .clk       (clk),
    .rst_q_n   (rst_q_n),
    .fetch_vld (fetch_vld),
    .act       (act),
    .occ       (occ)
  );

  always_comb begin
    pc_we        = (act != ACT_STALL);
    ifid_hold    = (act == ACT_STALL);
    idex_bubble  = (act == ACT_STALL);
    ifid_squash  = (act == ACT_FLUSH);
    idex_squash  = (act == ACT_FLUSH);
    exmem_squash = (act == ACT_FLUSH);
    id_vld       = occ.id;
    ex_vld       = occ.ex;
    mem_vld      = occ.mem;
    wb_vld       = occ.wb;
  end
endmodule

// File: rtl/hz_pipe_ctrl_chk.sv
module hz_pipe_ctrl_chk #(
  parameter int unsigned REG_AW  = 5,
  parameter int unsigned NUM_SRC = 2
) (
  input logic                      clk,
  input logic                      rst_q_n,
  input logic [NUM_SRC*REG_AW-1:0] id_src_addr,
  input logic                      mem_br_taken,
  input logic                      pc_we,
  input logic                      ifid_hold,
  input logic                      idex_bubble,
  input logic                      ifid_squash,
  input logic                      idex_squash,
  input logic                      exmem_squash,
  input logic                      id_vld,
  input logic                      ex_vld,
  input logic                      mem_vld,
  input logic                      wb_vld
);
  // R3: a bubble freezes the program counter
  p_bubble_freezes_pc_r3: assert property (@(posedge clk) disable iff (!rst_q_n)
    idex_bubble |-> !pc_we);

  // R3: the held decode instruction stays, execute empties
  p_hold_keeps_decode_r3: assert property (@(posedge clk) disable iff (!rst_q_n)
    (ifid_hold && idex_bubble) |=> (id_vld && !ex_vld));

  // R2: free flow shifts occupancy by one stage
  p_flow_shift_r2: assert property (@(posedge clk) disable iff (!rst_q_n)
    (!ifid_hold && !exmem_squash) |=>
      (ex_vld == $past(id_vld) && mem_vld == $past(ex_vld) && wb_vld == $past(mem_vld)));

  // R8: flush empties the three younger stages, branch reaches writeback
  p_flush_clears_r8: assert property (@(posedge clk) disable iff (!rst_q_n)
    exmem_squash |=> (!id_vld && !ex_vld && !mem_vld && wb_vld));

  // R8: squash strobes move together
  p_squash_aligned_r8: assert property (@(posedge clk) disable iff (!rst_q_n)
    (ifid_squash == exmem_squash) && (idex_squash == exmem_squash));

  // R9: flush beats stall
  p_flush_wins_r9: assert property (@(posedge clk) disable iff (!rst_q_n)
    ifid_squash |-> (!ifid_hold && !idex_bubble && pc_we));

  // R10: branch flag with empty memory stage squashes nothing
  p_empty_branch_ignored_r10: assert property (@(posedge clk) disable iff (!rst_q_n)
    (mem_br_taken && !mem_vld) |-> !exmem_squash);

  // R6: all-zero sources never stall
  p_zero_reg_free_r6: assert property (@(posedge clk) disable iff (!rst_q_n)
    (id_src_addr == '0) |-> !idex_bubble);

  // R7: an empty decode stage never stalls
  p_empty_decode_free_r7: assert property (@(posedge clk) disable iff (!rst_q_n)
    !id_vld |-> !ifid_hold);
endmodule

bind hz_pipe_ctrl hz_pipe_ctrl_chk #(.REG_AW(REG_AW), .NUM_SRC(NUM_SRC)) u_chk (
  .clk          (clk),
  .rst_q_n      (rst_q_n),
  .id_src_addr  (id_src_addr),
  .mem_br_taken (mem_br_taken),
  .pc_we        (pc_we),
  .ifid_hold    (ifid_hold),
  .idex_bubble  (idex_bubble),
  .ifid_squash  (ifid_squash),
  .idex_squash  (idex_squash),
  .exmem_squash (exmem_squash),
  .id_vld       (id_vld),
  .ex_vld       (ex_vld),
  .mem_vld      (mem_vld),
  .wb_vld       (wb_vld)
);

// File: tb/tb_hz_pipe_ctrl.sv
`timescale 1ns/1ps
module tb_hz_pipe_ctrl;
  localparam int unsigned AW = 5;
  localparam int unsigned NS = 2;

  logic          clk;
  logic          rst_n;
  logic          fetch_vld;
  logic [NS*AW-1:0] id_src_addr;
  logic [NS-1:0] id_src_use;
  logic          ex_wen;
  logic [AW-1:0] ex_rd;
  logic          mem_wen;
  logic [AW-1:0] mem_rd;
  logic          mem_br_taken;
  logic pc_we, ifid_hold, idex_bubble, ifid_squash, idex_squash, exmem_squash;
  logic id_vld, ex_vld, mem_vld, wb_vld;

  hz_pipe_ctrl #(.REG_AW(AW), .NUM_SRC(NS)) dut (
    .clk(clk), .rst_n(rst_n), .fetch_vld(fetch_vld),
    .id_src_addr(id_src_addr), .id_src_use(id_src_use),
    .ex_wen(ex_wen), .ex_rd(ex_rd), .mem_wen(mem_wen), .mem_rd(mem_rd),
    .mem_br_taken(mem_br_taken), .pc_we(pc_we), .ifid_hold(ifid_hold),
    .idex_bubble(idex_bubble), .ifid_squash(ifid_squash),
    .idex_squash(idex_squash), .exmem_squash(exmem_squash),
    .id_vld(id_vld), .ex_vld(ex_vld), .mem_vld(mem_vld), .wb_vld(wb_vld)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  typedef struct {
    logic [3:0] ctl;   // {pc_we, hold, bubble, squash}
    logic [3:0] occ;   // {id, ex, mem, wb}
    string      tag;
  } exp_t;

  exp_t exp_q[$];
  int   total = 0;
  int   bad   = 0;
  bit   done  = 0;

  task automatic step(input logic fv,
                      input logic [AW-1:0] s0, input logic u0,
                      input logic [AW-1:0] s1, input logic u1,
                      input logic ew, input logic [AW-1:0] ed,
                      input logic mw, input logic [AW-1:0] md,
                      input logic bt,
                      input logic [3:0] ectl, input logic [3:0] eocc,
                      input string tag);
    exp_t e;
    @(negedge clk);
    fetch_vld    = fv;
    id_src_addr  = {s1, s0};
    id_src_use   = {u1, u0};
    ex_wen       = ew;
    ex_rd        = ed;
    mem_wen      = mw;
    mem_rd       = md;
    mem_br_taken = bt;
    e.ctl = ectl;
    e.occ = eocc;
    e.tag = tag;
    exp_q.push_back(e);
  endtask

  // monitor: pops each expectation and compares mid-cycle
  initial begin
    forever begin
      @(negedge clk);
      #4;
      if (exp_q.size() > 0) begin
        exp_t e;
        logic [3:0] actl;
        logic [3:0] aocc;
        e = exp_q.pop_front();
        actl = {pc_we, ifid_hold, idex_bubble, exmem_squash};
        aocc = {id_vld, ex_vld, mem_vld, wb_vld};
        total++;
        if (actl !== e.ctl || aocc !== e.occ ||
            ifid_squash !== e.ctl[0] || idex_squash !== e.ctl[0]) begin
          bad++;
          $display("FAIL %s: ctl=%b occ=%b sq=%b%b expected ctl=%b occ=%b",
                   e.tag, actl, aocc, ifid_squash, idex_squash, e.ctl, e.occ);
        end
      end
    end
  end

  initial begin
    #(20 * 5000);
    if (!done) begin
      bad++;
      total++;
      $display("FAIL watchdog: run did not complete, actual=hung expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0;
    fetch_vld = 0; id_src_addr = '0; id_src_use = '0;
    ex_wen = 0; ex_rd = '0; mem_wen = 0; mem_rd = '0; mem_br_taken = 0;
    // R1: reset state, even with fetch asserted
    step(1, 0,0, 0,0, 0,0, 0,0, 0, 4'b1000, 4'b0000, "R1 reset");
    step(1, 0,0, 0,0, 0,0, 0,0, 0, 4'b1000, 4'b0000, "R1 reset held");
    @(negedge clk);
    rst_n = 1'b1;
    step(0, 0,0, 0,0, 0,0, 0,0, 0, 4'b1000, 4'b0000, "R1 sync release");
    step(0, 0,0, 0,0, 0,0, 0,0, 0, 4'b1000, 4'b0000, "R1 sync release");
    step(0, 0,0, 0,0, 0,0, 0,0, 0, 4'b1000, 4'b0000, "R1 idle");
    // R2: fill
    step(1, 0,0, 0,0, 0,0, 0,0, 0, 4'b1000, 4'b0000, "R2 fill0");
    step(1, 0,0, 0,0, 0,0, 0,0, 0, 4'b1000, 4'b1000, "R2 fill1");
    step(1, 0,0, 0,0, 0,0, 0,0, 0, 4'b1000, 4'b1100, "R2 fill2");
    step(1, 0,0, 0,0, 0,0, 0,0, 0, 4'b1000, 4'b1110, "R2 fill3");
    step(1, 0,0, 0,0, 0,0, 0,0, 0, 4'b1000, 4'b1111, "R2 full");
    // R3: src0=3 vs EX dest 3
    step(1, 3,1, 0,0, 1,3, 0,0, 0, 4'b0110, 4'b1111, "R3 ex dependence");
    // R4: producer now in MEM
    step(1, 3,1, 0,0, 0,0, 1,3, 0, 4'b0110, 4'b1011, "R4 mem dependence");
    // R5: producer in WB, no match in EX/MEM
    step(1, 3,1, 0,0, 0,0, 0,0, 0, 4'b1000, 4'b1001, "R5 wb release");
    // R6: register 0
    step(1, 0,1, 0,1, 1,0, 1,0, 0, 4'b1000, 4'b1100, "R6 zero reg");
    // R7: unused source
    step(1, 0,0, 7,0, 1,7, 0,0, 0, 4'b1000, 4'b1110, "R7 unused src");
    // R7: write enable off
    step(1, 0,0, 9,1, 0,9, 0,9, 0, 4'b1000, 4'b1111, "R7 no wen");
    // R8/R9: taken branch with concurrent stall
    step(1, 4,1, 0,0, 1,4, 0,0, 1, 4'b1001, 4'b1111, "R9 flush over stall");
    // R10: branch flag with empty MEM; R7 empty producer
    step(1, 4,1, 0,0, 1,4, 0,0, 1, 4'b1000, 4'b0001, "R10 empty mem branch");
    // R7: EX stage empty
    step(0, 5,1, 0,0, 1,5, 0,0, 0, 4'b1000, 4'b1000, "R7 empty ex");
    // R7: decode empty
    step(0, 5,1, 0,0, 1,5, 0,0, 0, 4'b1000, 4'b0100, "R7 empty decode");
    // R8: plain flush
    step(1, 0,0, 0,0, 0,0, 0,0, 1, 4'b1001, 4'b0010, "R8 flush");
    step(0, 0,0, 0,0, 0,0, 0,0, 0, 4'b1000, 4'b0001, "R8 after flush");
    step(1, 0,0, 0,0, 0,0, 0,0, 0, 4'b1000, 4'b0000, "R2 drained");
    step(1, 0,0, 0,0, 0,0, 0,0, 0, 4'b1000, 4'b1000, "R2 refill");
    // R3: second source vs EX
    step(1, 0,0, 6,1, 1,6, 0,0, 0, 4'b0110, 4'b1100, "R3 src1 ex");
    // R4: second source vs MEM
    step(1, 0,0, 6,1, 0,0, 1,6, 0, 4'b0110, 4'b1010, "R4 src1 mem");
    step(1, 0,0, 6,1, 0,0, 0,0, 0, 4'b1000, 4'b1001, "R5 src1 release");
    step(0, 0,0, 0,0, 0,0, 0,0, 0, 4'b1000, 4'b1100, "R2 resume");
    @(negedge clk);
    #8;
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule